// File: doc/BRIEF.md
# Embedded-Clock Link Deframer

This block sits behind the comparators of a point-to-point display link receiver. It is fed one symbol per clock cycle, already classified: a flag for a level above the high reference, a flag for a level below the low reference, and the data bit for symbols between the two references. The block treats either flag as a clock marker. It uses the markers to locate frame boundaries and discards the marker slot and the tail slot that follows it. It then reads the embedded data-enable bit and rebuilds either a 30-bit pixel word or a control word.

Two formats are supported. In the deep format, every pixel frame spans 36 unit intervals and contains two markers, one every 18 slots. In the shallow format, a frame spans 24 slots and contains a single marker. After reset the block searches for a properly spaced pair of markers before it emits any word. While locked it checks every marker position and reports violations through a sticky framing-error flag. After a violation it realigns on the next marker.

Top module: `emb_clk_deframer`

## Requirements
- R1: A symbol is a clock marker when `sym_hi_i` or `sym_lo_i` is 1; both polarities work identically. The data bit `sym_dat_i` is used only on non-marker symbols.
- R2: After reset no word is produced until two markers exactly one marker period apart have been seen; the second of them starts the first frame.
- R3: With `mode6_i`=0 (deep format) the marker period is 18 slots and a frame holds two markers; with `mode6_i`=1 (shallow format) the period is 24 slots and a frame holds one marker. Correctly spaced markers never raise an error.
- R4: Slot 1 after every marker (the tail) is discarded whatever its value.
- R5: Slot 2 after a frame's first marker is the DE bit; the reserved slots (slot 3 in the deep format, slots 3 to 5 in the shallow format) are discarded.
- R6: Deep format: slots 4 to 17 of the first half carry red[9:0] then green[9:6]; slots 2 to 17 of the second half carry green[5:0] then blue[9:0], MSB first; `pix_o` = {red, green, blue} with red in bits 29:20.
- R7: Shallow format: slots 6 to 23 carry red[5:0], green[5:0], blue[5:0], MSB first; each color is placed in the upper 6 bits of its 10-bit field of `pix_o`, with the lower 4 bits zero.
- R8: With DE=1 the payload updates `pix_o` and `ctl_o` holds. With DE=0 the payload updates `ctl_o` and `pix_o` holds. `ctl_o` holds the payload bits in arrival order, with the last bit in bit 0 and zeros above the 18 bits in the shallow format. `de_o` is the DE of the last word.
- R9: `word_vld_o` is high for exactly one cycle, the cycle after the last payload slot is sampled, and the word outputs are valid in that cycle.
- R10: A marker at an unexpected slot while locked sets `frm_err_o`, which stays set until reset; that marker starts a new frame.
- R11: A missing marker at an expected slot while locked sets `frm_err_o`; the following non-marker symbols are ignored, and the next marker starts a new frame without a new search.
- R12: During and right after reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock, one unit interval per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_hi_i | input | 1 | Symbol above the high reference |
| sym_lo_i | input | 1 | Symbol below the low reference |
| sym_dat_i | input | 1 | Data bit of a mid-range symbol |
| mode6_i | input | 1 | 0 = deep 10-bit format, 1 = shallow 6-bit format |
| pix_o | output | 30 | Last pixel word {red, green, blue} |
| de_o | output | 1 | DE bit of the last word |
| ctl_o | output | 30 | Last control word |
| word_vld_o | output | 1 | One-cycle strobe for a new word |
| frm_err_o | output | 1 | Sticky framing error |

## Verification
The assertions assume that the comparator front end never reports a symbol as both above and below the references in the same cycle. The bench drives each marker with exactly one flag, chosen per frame. The assertions also assume that `mode6_i` stays constant between resets. The bench changes the format only while reset is held, and it gives every scenario its own search sequence.

// File: rtl/emb_clk_deframer_pkg.sv
package emb_clk_deframer_pkg;
  typedef enum logic [1:0] {
    TRK_HUNT = 2'd0,
    TRK_PAIR = 2'd1,
    TRK_LOCK = 2'd2,
    TRK_LOST = 2'd3
  } trk_state_e;
endpackage

// File: rtl/sym_classify.sv
module sym_classify (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_i,
  input  logic lo_i,
  input  logic dat_i,
  output logic mark_o,
  output logic dbit_o
);
  always_comb begin
    mark_o = hi_i | lo_i;
    dbit_o = dat_i & ~mark_o;
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hi_i, lo_i})); // R1
endmodule

// File: rtl/slot_tracker.sv
module slot_tracker
  import emb_clk_deframer_pkg::*;
#(
  parameter int HALF_P   = 18,
  parameter int FRAME6_P = 24,
  parameter int PAY6_OFS = 6,
  parameter int CNT_W    = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode6_i,
  input  logic mark_i,
  output logic locked_o,
  output logic frame_start_o,
  output logic de_slot_o,
  output logic pay_slot_o,
  output logic last_slot_o,
  output logic err_o
);
  localparam logic [CNT_W-1:0] HALF_M1  = CNT_W'(HALF_P - 1);
  localparam logic [CNT_W-1:0] FRM6_M1  = CNT_W'(FRAME6_P - 1);
  localparam logic [CNT_W-1:0] OFS_A    = CNT_W'(4);
  localparam logic [CNT_W-1:0] OFS_B    = CNT_W'(2);
  localparam logic [CNT_W-1:0] OFS_6    = CNT_W'(PAY6_OFS);
  localparam logic [CNT_W-1:0] DE_SLOT  = CNT_W'(2);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO     = '0;

  trk_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc, period_m1, first_pay;
  logic              half_q, half_d;
  logic              err_q, err_d;
  logic              start_c, act_c;

  always_comb begin
    period_m1 = mode6_i ? FRM6_M1 : HALF_M1;
    first_pay = mode6_i ? OFS_6 : (half_q ? OFS_B : OFS_A);
    cnt_inc   = (cnt_q == period_m1) ? ZERO : cnt_q + ONE;
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_inc;
    half_d  = half_q;
    err_d   = err_q;
    start_c = 1'b0;
    unique case (state_q)
      TRK_HUNT: begin
        if (mark_i) begin
          state_d = TRK_PAIR;
          cnt_d   = ONE;
        end else begin
          cnt_d   = ZERO;
        end
      end
      TRK_PAIR: begin
        if (mark_i) begin
          cnt_d = ONE;
          if (cnt_q == ZERO) begin
            state_d = TRK_LOCK;
            half_d  = 1'b0;
            start_c = 1'b1;
          end
        end else if (cnt_q == ZERO) begin
          state_d = TRK_HUNT;
          cnt_d   = ZERO;
        end
      end
      TRK_LOCK: begin
        if (mark_i) begin
          cnt_d = ONE;
          if (cnt_q == ZERO && !mode6_i && !half_q) begin
            half_d = 1'b1;
          end else begin
            half_d  = 1'b0;
            start_c = 1'b1;
            if (cnt_q != ZERO) err_d = 1'b1;
          end
        end else if (cnt_q == ZERO) begin
          err_d   = 1'b1;
          state_d = TRK_LOST;
          cnt_d   = ZERO;
        end
      end
      TRK_LOST: begin
        if (mark_i) begin
          state_d = TRK_LOCK;
          cnt_d   = ONE;
          half_d  = 1'b0;
          start_c = 1'b1;
        end else begin
          cnt_d   = ZERO;
        end
      end
      default: begin
        state_d = TRK_HUNT;
        cnt_d   = ZERO;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TRK_HUNT;
      cnt_q   <= '0;
      half_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      half_q  <= half_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    act_c         = (state_q == TRK_LOCK) && !mark_i && (cnt_q != ZERO);
    locked_o      = (state_q == TRK_LOCK);
    frame_start_o = start_c;
    de_slot_o     = act_c && !half_q && (cnt_q == DE_SLOT);
    pay_slot_o    = act_c && (cnt_q >= first_pay);
    last_slot_o   = act_c && (cnt_q == period_m1) && (mode6_i || half_q);
    err_o         = err_q;
  end

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FRM6_M1 && (mode6_i || cnt_q <= HALF_M1)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R10
  AST_LOST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TRK_LOST) |-> !pay_slot_o && !de_slot_o); // R11
endmodule

// File: rtl/word_assembler.sv
module word_assembler #(
  parameter int COLOR_W    = 10,
  parameter int LO_COLOR_W = 6,
  parameter int PAY_W      = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode6_i,
  input  logic             dbit_i,
  input  logic             frame_start_i,
  input  logic             de_slot_i,
  input  logic             pay_slot_i,
  input  logic             last_slot_i,
  output logic [PAY_W-1:0] pix_o,
  output logic [PAY_W-1:0] ctl_o,
  output logic             de_o,
  output logic             vld_o
);
  localparam int PAD_W = COLOR_W - LO_COLOR_W;

  logic [PAY_W-1:0] sr_q, sr_d, pix6_c, pix_sel;
  logic             sr_en, de_q, de_d, de_en;
  logic             pix_en, ctl_en;

  always_comb begin
    sr_en = frame_start_i | pay_slot_i;
    if (frame_start_i) sr_d = '0;
    else if (pay_slot_i) sr_d = {sr_q[PAY_W-2:0], dbit_i};
    else sr_d = sr_q;
    de_en  = de_slot_i;
    de_d   = dbit_i;
    pix_en = last_slot_i & de_q;
    ctl_en = last_slot_i & ~de_q;
  end

  for (genvar c = 0; c < 3; c++) begin : g_lo_map
    assign pix6_c[c*COLOR_W +: COLOR_W] = {sr_d[c*LO_COLOR_W +: LO_COLOR_W], {PAD_W{1'b0}}};
  end

  assign pix_sel = mode6_i ? pix6_c : sr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      de_q  <= 1'b0;
      pix_o <= '0;
      ctl_o <= '0;
      de_o  <= 1'b0;
      vld_o <= 1'b0;
    end else begin
      if (sr_en)       sr_q  <= sr_d;
      if (de_en)       de_q  <= de_d;
      if (pix_en)      pix_o <= pix_sel;
      if (ctl_en)      ctl_o <= sr_d;
      if (last_slot_i) de_o  <= de_q;
      vld_o <= last_slot_i;
    end
  end

  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |=> !vld_o); // R9
  AST_SLOT_KINDS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_start_i, de_slot_i, pay_slot_i})); // R5
  AST_PIX_HELD_ON_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && !de_o) |-> $stable(pix_o)); // R8
endmodule

// File: rtl/emb_clk_deframer.sv
module emb_clk_deframer #(
  parameter int COLOR_W    = 10,
  parameter int LO_COLOR_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sym_hi_i,
  input  logic                 sym_lo_i,
  input  logic                 sym_dat_i,
  input  logic                 mode6_i,
  output logic [3*COLOR_W-1:0] pix_o,
  output logic                 de_o,
  output logic [3*COLOR_W-1:0] ctl_o,
  output logic                 word_vld_o,
  output logic                 frm_err_o
);
  localparam int PAY_W    = 3 * COLOR_W;
  localparam int HALF_P   = (3 * COLOR_W + 6) / 2;
  localparam int FRAME6_P = 3 * LO_COLOR_W + 6;
  localparam int PAY6_OFS = FRAME6_P - 3 * LO_COLOR_W;
  localparam int MAX_P    = (HALF_P > FRAME6_P) ? HALF_P : FRAME6_P;
  localparam int CNT_W    = $clog2(MAX_P);

  logic [1:0] rst_q;
  logic       rst_int_n;
  logic       mark, dbit, locked, fstart, de_slot, pay_slot, last_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  sym_classify u_cls (
    .clk   (clk),
    .rst_n (rst_int_n),
    .hi_i  (sym_hi_i),
    .lo_i  (sym_lo_i),
    .dat_i (sym_dat_i),
    .mark_o(mark),
    .dbit_o(dbit)
  );

  slot_tracker #(
    .HALF_P  (HALF_P),
    .FRAME6_P(FRAME6_P),
    .PAY6_OFS(PAY6_OFS),
    .CNT_W   (CNT_W)
  ) u_trk (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .mode6_i      (mode6_i),
    .mark_i       (mark),
    .locked_o     (locked),
    .frame_start_o(fstart),
    .de_slot_o    (de_slot),
    .pay_slot_o   (pay_slot),
    .last_slot_o  (last_slot),
    .err_o        (frm_err_o)
  );

  word_assembler #(
    .COLOR_W   (COLOR_W),
    .LO_COLOR_W(LO_COLOR_W),
    .PAY_W     (PAY_W)
  ) u_asm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .mode6_i      (mode6_i),
    .dbit_i       (dbit),
    .frame_start_i(fstart),
    .de_slot_i    (de_slot),
    .pay_slot_i   (pay_slot),
    .last_slot_i  (last_slot),
    .pix_o        (pix_o),
    .ctl_o        (ctl_o),
    .de_o         (de_o),
    .vld_o        (word_vld_o)
  );

  AST_QUIET_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_int_n)
    !locked |=> !word_vld_o); // R2
endmodule

// File: tb/emb_clk_deframer_test.sv
`timescale 1ns/1ps
module emb_clk_deframer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        s_hi, s_lo, s_dat, mode6;
  logic [29:0] pix, ctl;
  logic        de, vld, err;
  int          checks = 0;
  int          errors = 0;
  int          vld_cnt = 0;

  always #4 clk = ~clk;

  emb_clk_deframer uut (
    .clk(clk), .rst_n(rst_n), .sym_hi_i(s_hi), .sym_lo_i(s_lo), .sym_dat_i(s_dat),
    .mode6_i(mode6), .pix_o(pix), .de_o(de), .ctl_o(ctl), .word_vld_o(vld), .frm_err_o(err)
  );

  always @(posedge clk) begin
    #1;
    if (vld) vld_cnt++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic sd(input logic b);
    s_hi = 1'b0; s_lo = 1'b0; s_dat = b;
    @(negedge clk);
  endtask

  task automatic mk(input logic low);
    s_hi = ~low; s_lo = low; s_dat = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic m6);
    rst_n = 1'b0; mode6 = m6;
    s_hi = 1'b0; s_lo = 1'b0; s_dat = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic acquire(input int period);
    mk(1'b0);
    for (int i = 1; i < period; i++) sd(i[0]);
  endtask

  task automatic frame10(input logic dev, input logic [9:0] r, g, b,
                         input logic low, input logic tail, input logic rsv);
    mk(low); sd(tail); sd(dev); sd(rsv);
    for (int i = 9; i >= 0; i--) sd(r[i]);
    for (int i = 9; i >= 6; i--) sd(g[i]);
    mk(low); sd(tail);
    for (int i = 5; i >= 0; i--) sd(g[i]);
    for (int i = 9; i >= 0; i--) sd(b[i]);
  endtask

  task automatic frame6(input logic dev, input logic [5:0] r, g, b,
                        input logic low, input logic tail, input logic rsv);
    mk(low); sd(tail); sd(dev); sd(rsv); sd(~rsv); sd(rsv);
    for (int i = 5; i >= 0; i--) sd(r[i]);
    for (int i = 5; i >= 0; i--) sd(g[i]);
    for (int i = 5; i >= 0; i--) sd(b[i]);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; mode6 = 1'b0; s_hi = 1'b0; s_lo = 1'b0; s_dat = 1'b0;
    repeat (2) @(negedge clk);
    check("R12 pix in reset", {2'b0, pix}, 32'h0);
    check("R12 ctl in reset", {2'b0, ctl}, 32'h0);
    check("R12 flags in reset", {28'h0, de, vld, err, 1'b0}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R12 flags after release", {29'h0, de, vld, err}, 32'h0);
  endtask

  task automatic t_hunt();
    do_reset(1'b0);
    vld_cnt = 0;
    mk(1'b0); repeat (7) sd(1'b1);
    mk(1'b1); repeat (5) sd(1'b0);
    repeat (40) sd(1'b1);
    check("R2 no word while hunting", vld_cnt, 0);
    acquire(18);
    frame10(1'b1, 10'h2B5, 10'h1C3, 10'h3A6, 1'b0, 1'b0, 1'b1);
    check("R2 first word after acquisition", {31'h0, vld}, 32'h1);
    check("R2 first pixel", {2'b0, pix}, {2'b0, 10'h2B5, 10'h1C3, 10'h3A6});
  endtask

  task automatic t_deep();
    do_reset(1'b0);
    acquire(18);
    vld_cnt = 0;
    frame10(1'b1, 10'h155, 10'h2F0, 10'h00F, 1'b0, 1'b0, 1'b1);
    check("R9 strobe in last cycle", {31'h0, vld}, 32'h1);
    check("R6 deep pixel order", {2'b0, pix}, {2'b0, 10'h155, 10'h2F0, 10'h00F});
    check("R8 de_o for pixel", {31'h0, de}, 32'h1);
    check("R8 ctl held on pixel", {2'b0, ctl}, 32'h0);
    frame10(1'b1, 10'h3C1, 10'h0A7, 10'h21E, 1'b1, 1'b1, 1'b0);
    check("R1 low markers accepted", {2'b0, pix}, {2'b0, 10'h3C1, 10'h0A7, 10'h21E});
    check("R4 opposite tail ignored", {31'h0, vld}, 32'h1);
    frame10(1'b0, 10'h0F3, 10'h35A, 10'h1B4, 1'b0, 1'b1, 1'b1);
    check("R8 ctl word", {2'b0, ctl}, {2'b0, 10'h0F3, 10'h35A, 10'h1B4});
    check("R8 pix held on ctl", {2'b0, pix}, {2'b0, 10'h3C1, 10'h0A7, 10'h21E});
    check("R8 de_o for ctl", {31'h0, de}, 32'h0);
    check("R9 one pulse per frame", vld_cnt, 3);
    check("R3 deep spacing no error", {31'h0, err}, 32'h0);
    check("R5 reserved ignored", {2'b0, pix}, {2'b0, 10'h3C1, 10'h0A7, 10'h21E});
  endtask

  task automatic t_shallow();
    do_reset(1'b1);
    acquire(24);
    vld_cnt = 0;
    frame6(1'b1, 6'h2D, 6'h13, 6'h3A, 1'b1, 1'b0, 1'b1);
    check("R7 shallow pixel",  {2'b0, pix},
          {2'b0, 6'h2D, 4'h0, 6'h13, 4'h0, 6'h3A, 4'h0});
    frame6(1'b0, 6'h31, 6'h0E, 6'h25, 1'b0, 1'b1, 1'b0);
    check("R8 shallow ctl", {2'b0, ctl}, {14'h0, 6'h31, 6'h0E, 6'h25});
    check("R3 shallow single marker", vld_cnt, 2);
    check("R3 shallow no error", {31'h0, err}, 32'h0);
  endtask

  task automatic t_unexpected();
    do_reset(1'b0);
    acquire(18);
    mk(1'b0); sd(1'b0); sd(1'b1); sd(1'b0); sd(1'b1); sd(1'b1); sd(1'b0);
    check("R10 no error yet", {31'h0, err}, 32'h0);
    frame10(1'b1, 10'h0C9, 10'h3E2, 10'h11D, 1'b0, 1'b0, 1'b0);
    check("R10 error raised", {31'h0, err}, 32'h1);
    check("R10 realigned pixel", {2'b0, pix}, {2'b0, 10'h0C9, 10'h3E2, 10'h11D});
    frame10(1'b1, 10'h200, 10'h001, 10'h3FF, 1'b1, 1'b1, 1'b1);
    check("R10 error sticky", {31'h0, err}, 32'h1);
    check("R10 later pixel", {2'b0, pix}, {2'b0, 10'h200, 10'h001, 10'h3FF});
  endtask

  task automatic t_missing();
    do_reset(1'b0);
    acquire(18);
    frame10(1'b1, 10'h111, 10'h222, 10'h333, 1'b0, 1'b0, 1'b0);
    vld_cnt = 0;
    sd(1'b1);
    check("R11 missing marker error", {31'h0, err}, 32'h1);
    repeat (9) sd(1'b1);
    check("R11 ignored while lost", vld_cnt, 0);
    frame10(1'b1, 10'h2AA, 10'h155, 10'h0F0, 1'b1, 1'b0, 1'b1);
    check("R11 next marker starts frame", {2'b0, pix}, {2'b0, 10'h2AA, 10'h155, 10'h0F0});
    check("R11 single word", vld_cnt, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; mode6 = 1'b0; s_hi = 1'b0; s_lo = 1'b0; s_dat = 1'b0;
    @(negedge clk);
    t_reset();
    t_hunt();
    t_deep();
    t_shallow();
    t_unexpected();
    t_missing();
    finish_run();
  end
endmodule